// File: doc/BRIEF.md
# Multiplexed External Bus Access Sequencer

This block sits between an internal bus master and a time-multiplexed external memory bus. It takes one access request at a time and turns it into whole bus cycles. Each request carries an address, a read/write flag, write data and a region class. The region class is normal external space, emulation memory, or port-replacement space. Port-replacement space also covers the bus interface's own control registers. The block runs on a clock at twice the bus rate. Each bus cycle has two phases, an `eclk` high phase followed by an `eclk` low phase. The same pins carry the address in the high phase and status information in the low phase.

The length of an access and whether it appears on the external bus both depend on the region class and the operating mode. Normal external accesses can be stretched by 0 to 3 wait cycles in the expanded modes. Emulation memory is always a single cycle. Port-replacement accesses always take two cycles. In the emulation modes, a port-replacement write goes to both the internal register file and the external bus, and a port-replacement read is taken from the external bus. The requester keeps its request on the inputs until `reqReady` pulses. During that pulse it either replaces the request with the next one, which starts in the very next bus cycle, or removes it.

Top module: `extbus_sequencer`

## Requirements
- R1: A synchronous active-high reset leaves the sequencer idle: `reqReady` and `intWrEn` are low, `rw` is high, `dataOe` is low, and both address pin groups read 0.
- R2: A request with region code 2 (port-replacement or interface control register) takes exactly two bus cycles in every mode. The `mode` encoding is: bit 1 set means an emulation mode, and bit 0 set means an expanded mode.
- R3: A request with region code 1 (emulation memory) takes exactly one bus cycle and ignores `stretch`. It drives the external bus only in the emulation modes.
- R4: A request with region code 0 (normal external) takes 1 + `stretch` bus cycles in the expanded modes (mode 1 and mode 3) and drives the external bus.
- R5: An access that does not use the external bus keeps `rw` high, `dataOe` low and both address pin groups at 0 for its whole length. This applies to a normal external request outside the expanded modes, which takes one cycle. It also applies to emulation memory and port-replacement requests outside the emulation modes. A read of this kind from normal external or emulation memory space returns 0.
- R6: During an `eclk` high phase of a bus access, `addrHi` carries address bits 22:16 and `addrLo` carries address bits 15:0.
- R7: During an `eclk` low phase of a bus access, `addrHi` carries `{accCode, iqStat}` (access code in bits 6:4) and `addrLo` carries `ivd`.
- R8: For the whole of a bus access, `rw` is high for a read and low for a write. `dataOe` is high and `dataOut` carries the write data only for a write. A bus read returns the value present on `dataIn`.
- R9: Every port-replacement write pulses `intWrEn` once, together with `reqReady`, with `intWrData` equal to the write data. In the emulation modes the same write is also driven onto the external bus.
- R10: A port-replacement read returns `dataIn` in the emulation modes and `intRdData` otherwise.
- R11: `reqReady` is a single-clock pulse in the `eclk` low phase of the final bus cycle. A request present during that pulse starts in the next bus cycle. With no request present, the bus stays idle.
- R12: Region code 3 behaves exactly like normal external space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-cycle rate |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Access address |
| reqWdata | input | 16 | Write data |
| reqRegion | input | 2 | 0 external, 1 emulation memory, 2 port-replacement, 3 as external |
| mode | input | 2 | Bit 1 emulation, bit 0 expanded |
| stretch | input | 2 | Extra cycles for stretched external accesses |
| accCode | input | 3 | Access code shown in the low phase |
| iqStat | input | 4 | Queue status shown in the low phase |
| ivd | input | 16 | Internal visible data shown in the low phase |
| intRdData | input | 16 | Internal register read data |
| dataIn | input | 16 | External data bus input |
| reqReady | output | 1 | Access completion strobe |
| rdData | output | 16 | Read result, valid with reqReady |
| intWrEn | output | 1 | Internal register write strobe |
| intWrData | output | 16 | Internal register write data |
| intAddr | output | 23 | Address of the access in progress |
| eclk | output | 1 | Bus phase clock, high phase first |
| addrHi | output | 7 | Multiplexed upper address / access code / queue status pins |
| addrLo | output | 16 | Multiplexed lower address / visible data pins |
| rw | output | 1 | High for read, low for write |
| dataOut | output | 16 | External data bus output value |
| dataOe | output | 1 | External data bus drive enable |

## Verification
The bench sweeps every combination of mode, stretch value, region code and direction as one unbroken back-to-back stream. Length, pin multiplexing, drive direction and the read data source all change across that stream. Each access is timed by counting its high phases and is compared against lengths and pin values computed from the requirements. Several faults would show up as a wrong count. One is stretching emulation memory or port-replacement accesses. Another is applying wait cycles in a non-expanded mode. A third is letting a port-replacement access fall to one cycle. Showing the low-phase status fields in the high phase, or the reverse, would show up as a pin mismatch. A port-replacement read taken from the wrong side would return the internal value where the external one was due. A sequencer that re-accepted a stale request after its ready pulse would be seen driving the bus after the stream ends.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [1:0] {
    REGION_EXTERNAL = 2'd0,
    REGION_EMUMEM   = 2'd1,
    REGION_PORTREP  = 2'd2,
    REGION_SPARE    = 2'd3
  } region_e;

  // Strobes and per-access flags the control hands to the datapath.
  typedef struct packed {
    logic load;       // latch a new request this edge
    logic active;     // an access is in progress
    logic phaseLow;   // current phase is the eclk low phase
    logic capture;    // latch read data this edge
    logic isWrite;    // access direction
    logic driveBus;   // access appears on the external bus
    logic readInt;    // read result comes from the internal register file
    logic readZero;   // read result is zero (no bus, no register)
  } seqStrobes_t;

endpackage

// File: rtl/extbus_seq_ctrl.sv
module extbus_seq_ctrl
  import extbus_pkg::*;
#(
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqRegion,
  input  logic [1:0]           mode,
  input  logic [STRETCH_W-1:0] stretch,
  output seqStrobes_t          st,
  output logic                 reqReady,
  output logic                 intWrEn
);

  localparam int CNT_W = STRETCH_W + 1;

  logic             phaseLow;
  logic             busy;
  logic [CNT_W-1:0] remain;
  logic             curWrite;
  logic             curPortRep;
  logic             curDrive;
  logic             curReadInt;
  logic             curReadZero;

  // Classification of the incoming request
  logic             isPortRep;
  logic             isEmuMem;
  logic             emulMode;
  logic             expandMode;
  logic             nextDrive;
  logic [CNT_W-1:0] nextRemain;
  logic             lastCycle;
  logic             accept;

  always_comb begin
    isPortRep  = (region_e'(reqRegion) == REGION_PORTREP);
    isEmuMem   = (region_e'(reqRegion) == REGION_EMUMEM);
    emulMode   = mode[1];
    expandMode = mode[0];

    if (isPortRep)                    nextRemain = CNT_W'(1);
    else if (!isEmuMem && expandMode) nextRemain = CNT_W'(stretch);
    else                              nextRemain = '0;

    if (isPortRep || isEmuMem) nextDrive = emulMode;
    else                       nextDrive = expandMode;

    lastCycle = busy && (remain == '0);
    accept    = phaseLow && reqValid && (!busy || lastCycle);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseLow    <= 1'b0;
      busy        <= 1'b0;
      remain      <= '0;
      curWrite    <= 1'b0;
      curPortRep  <= 1'b0;
      curDrive    <= 1'b0;
      curReadInt  <= 1'b0;
      curReadZero <= 1'b0;
      reqReady    <= 1'b0;
      intWrEn     <= 1'b0;
    end else begin
      phaseLow <= ~phaseLow;
      reqReady <= !phaseLow && lastCycle;
      intWrEn  <= !phaseLow && lastCycle && curPortRep && curWrite;
      if (phaseLow) begin
        if (accept) begin
          busy        <= 1'b1;
          remain      <= nextRemain;
          curWrite    <= reqWrite;
          curPortRep  <= isPortRep;
          curDrive    <= nextDrive;
          curReadInt  <= isPortRep && !emulMode;
          curReadZero <= !isPortRep && !nextDrive;
        end else if (busy) begin
          if (remain == '0) busy <= 1'b0;
          else              remain <= remain - 1'b1;
        end
      end
    end
  end

  always_comb begin
    st.load     = accept;
    st.active   = busy;
    st.phaseLow = phaseLow;
    st.capture  = !phaseLow && lastCycle;
    st.isWrite  = curWrite;
    st.driveBus = curDrive;
    st.readInt  = curReadInt;
    st.readZero = curReadZero;
  end

  // Assertions
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !reqReady && !intWrEn && !phaseLow));

  assert_ready_low_phase_R11: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> phaseLow);

  assert_ready_single_R11: assert property (@(posedge clk) disable iff (rst)
    reqReady |=> !reqReady);

  assert_start_on_boundary_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !phaseLow);

  assert_intwr_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
    intWrEn |-> reqReady);

endmodule

// File: rtl/extbus_seq_datapath.sv
module extbus_seq_datapath
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int ACC_W  = 3,
  parameter int IQ_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  seqStrobes_t         st,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [ACC_W-1:0]    accCode,
  input  logic [IQ_W-1:0]     iqStat,
  input  logic [DATA_W-1:0]   ivd,
  input  logic [DATA_W-1:0]   intRdData,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   intWrData,
  output logic [ADDR_W-1:0]   intAddr,
  output logic                eclk,
  output logic [ACC_W+IQ_W-1:0] addrHi,
  output logic [DATA_W-1:0]   addrLo,
  output logic                rw,
  output logic [DATA_W-1:0]   dataOut,
  output logic                dataOe
);

  localparam int HI_W = ACC_W + IQ_W;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic              onBus;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      curWdata <= '0;
      rdData   <= '0;
    end else begin
      if (st.load) begin
        curAddr  <= reqAddr;
        curWdata <= reqWdata;
      end
      if (st.capture) begin
        if (st.readZero)     rdData <= '0;
        else if (st.readInt) rdData <= intRdData;
        else                 rdData <= dataIn;
      end
    end
  end

  always_comb begin
    onBus   = st.active && st.driveBus;
    eclk    = !st.phaseLow;
    addrHi  = '0;
    addrLo  = '0;
    rw      = 1'b1;
    dataOe  = 1'b0;
    dataOut = '0;
    if (onBus) begin
      if (st.phaseLow) begin
        addrHi = {accCode, iqStat};
        addrLo = ivd;
      end else begin
        addrHi = HI_W'(curAddr[ADDR_W-1:DATA_W]);
        addrLo = curAddr[DATA_W-1:0];
      end
      rw      = !st.isWrite;
      dataOe  = st.isWrite;
      dataOut = st.isWrite ? curWdata : '0;
    end
    intWrData = curWdata;
    intAddr   = curAddr;
  end

  // Assertions
  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !st.active |-> (rw && !dataOe && addrLo == '0 && addrHi == '0));

  assert_zero_read_R5: assert property (@(posedge clk) disable iff (rst)
    (st.capture && st.readZero) |=> (rdData == '0));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (st.active && !st.load) |=> $stable(curAddr) || $past(st.load));

endmodule

// File: rtl/extbus_sequencer.sv
module extbus_sequencer
  import extbus_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 3,
  parameter int IQ_W      = 4,
  parameter int STRETCH_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [1:0]             reqRegion,
  input  logic [1:0]             mode,
  input  logic [STRETCH_W-1:0]   stretch,
  input  logic [ACC_W-1:0]       accCode,
  input  logic [IQ_W-1:0]        iqStat,
  input  logic [DATA_W-1:0]      ivd,
  input  logic [DATA_W-1:0]      intRdData,
  input  logic [DATA_W-1:0]      dataIn,
  output logic                   reqReady,
  output logic [DATA_W-1:0]      rdData,
  output logic                   intWrEn,
  output logic [DATA_W-1:0]      intWrData,
  output logic [ADDR_W-1:0]      intAddr,
  output logic                   eclk,
  output logic [ACC_W+IQ_W-1:0]  addrHi,
  output logic [DATA_W-1:0]      addrLo,
  output logic                   rw,
  output logic [DATA_W-1:0]      dataOut,
  output logic                   dataOe
);

  seqStrobes_t st;

  extbus_seq_ctrl #(
    .STRETCH_W(STRETCH_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqRegion(reqRegion),
    .mode     (mode),
    .stretch  (stretch),
    .st       (st),
    .reqReady (reqReady),
    .intWrEn  (intWrEn)
  );

  extbus_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ACC_W (ACC_W),
    .IQ_W  (IQ_W)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .accCode  (accCode),
    .iqStat   (iqStat),
    .ivd      (ivd),
    .intRdData(intRdData),
    .dataIn   (dataIn),
    .rdData   (rdData),
    .intWrData(intWrData),
    .intAddr  (intAddr),
    .eclk     (eclk),
    .addrHi   (addrHi),
    .addrLo   (addrLo),
    .rw       (rw),
    .dataOut  (dataOut),
    .dataOe   (dataOe)
  );

endmodule

// File: tb/test_extbus_sequencer.sv
module test_extbus_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqRegion = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  stretch = '0;
  logic [2:0]  accCode = '0;
  logic [3:0]  iqStat = '0;
  logic [15:0] ivd = '0;
  logic [15:0] intRdData = '0;
  logic [15:0] dataIn = '0;
  logic        reqReady;
  logic [15:0] rdData;
  logic        intWrEn;
  logic [15:0] intWrData;
  logic [22:0] intAddr;
  logic        eclk;
  logic [6:0]  addrHi;
  logic [15:0] addrLo;
  logic        rw;
  logic [15:0] dataOut;
  logic        dataOe;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  extbus_sequencer i_extbus_sequencer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqRegion(reqRegion),
    .mode(mode), .stretch(stretch), .accCode(accCode), .iqStat(iqStat),
    .ivd(ivd), .intRdData(intRdData), .dataIn(dataIn), .reqReady(reqReady),
    .rdData(rdData), .intWrEn(intWrEn), .intWrData(intWrData),
    .intAddr(intAddr), .eclk(eclk), .addrHi(addrHi), .addrLo(addrLo),
    .rw(rw), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  // Launch a request at the current negedge (low phase) and follow it to reqReady.
  task automatic runAccess(input int idx, input bit wr, input logic [1:0] rg);
    bit isPr, isEm, emul, expd, bus, timedOut;
    int expLen, highCnt, readyCnt, readyHigh, wrCnt, badHi, badLo, badDrv;
    logic [15:0] expRd, gotRd, gotWrData;
    string lenTag, hiTag, loTag, drvTag, rdTag;

    reqValid  = 1'b1;
    reqWrite  = wr;
    reqRegion = rg;
    reqAddr   = {idx[6:0], 16'hA000 ^ idx[15:0]};
    reqWdata  = 16'h5A00 + 16'(idx * 3);
    accCode   = idx[2:0];
    iqStat    = 4'((idx * 5) % 16);
    ivd       = 16'hC000 | idx[15:0];
    dataIn    = 16'h3300 + idx[15:0];
    intRdData = 16'h7700 + idx[15:0];

    isPr = (rg == 2'd2);
    isEm = (rg == 2'd1);
    emul = mode[1];
    expd = mode[0];
    if (isPr)      expLen = 2;
    else if (isEm) expLen = 1;
    else if (expd) expLen = 1 + int'(stretch);
    else           expLen = 1;
    bus = (isPr || isEm) ? emul : expd;
    if (isPr && !emul) expRd = intRdData;
    else if (bus)      expRd = dataIn;
    else               expRd = 16'h0000;

    lenTag = isPr ? "R2" : isEm ? "R3" : (rg == 2'd3) ? "R12" : expd ? "R4" : "R5";
    hiTag  = bus ? "R6" : "R5";
    loTag  = bus ? "R7" : "R5";
    drvTag = !bus ? "R5" : (isPr && wr) ? "R9" : "R8";
    rdTag  = isPr ? "R10" : bus ? "R8" : "R5";

    highCnt = 0; readyCnt = 0; readyHigh = 0; wrCnt = 0;
    badHi = 0; badLo = 0; badDrv = 0; timedOut = 1'b1;
    gotRd = '0; gotWrData = '0;

    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (eclk) begin
        highCnt++;
        if (reqReady) readyHigh++;
        if (bus) begin
          if (addrHi !== reqAddr[22:16] || addrLo !== reqAddr[15:0]) badHi++;
        end else if (addrHi !== 7'd0 || addrLo !== 16'd0) badHi++;
      end else begin
        if (bus) begin
          if (addrHi !== {accCode, iqStat} || addrLo !== ivd) badLo++;
        end else if (addrHi !== 7'd0 || addrLo !== 16'd0) badLo++;
      end
      if (bus) begin
        if (rw !== !wr || dataOe !== wr || (wr && dataOut !== reqWdata)) badDrv++;
      end else if (rw !== 1'b1 || dataOe !== 1'b0) badDrv++;
      if (intWrEn) begin
        wrCnt++;
        gotWrData = intWrData;
      end
      if (reqReady) begin
        readyCnt++;
        gotRd = rdData;
        timedOut = 1'b0;
        break;
      end
    end

    check(!timedOut && highCnt == expLen, lenTag, "access length in bus cycles",
          32'(highCnt), 32'(expLen));
    check(badHi == 0, hiTag, "high-phase pin content", 32'(badHi), 32'd0);
    check(badLo == 0, loTag, "low-phase pin content", 32'(badLo), 32'd0);
    check(badDrv == 0, drvTag, "rw / data drive", 32'(badDrv), 32'd0);
    check(readyCnt == 1 && readyHigh == 0, "R11", "ready pulse in final low phase",
          32'(readyHigh), 32'd0);
    if (!wr)
      check(gotRd === expRd, rdTag, "read data", 32'(gotRd), 32'(expRd));
    check(wrCnt == ((isPr && wr) ? 1 : 0), "R9", "internal write strobe count",
          32'(wrCnt), 32'((isPr && wr) ? 1 : 0));
    if (isPr && wr)
      check(gotWrData === reqWdata, "R9", "internal write data",
            32'(gotWrData), 32'(reqWdata));
  endtask

  initial begin
    int idx;
    int stray;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady === 1'b0 && intWrEn === 1'b0, "R1", "strobes in reset",
          {30'd0, reqReady, intWrEn}, 32'd0);
    check(rw === 1'b1 && dataOe === 1'b0, "R1", "bus direction in reset",
          {30'd0, rw, dataOe}, 32'd2);
    check(addrHi === 7'd0 && addrLo === 16'd0, "R1", "address pins in reset",
          {9'd0, addrHi, addrLo}, 32'd0);
    rst = 1'b0;
    do @(negedge clk); while (eclk !== 1'b0);

    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int r = 0; r < 4; r++) begin
          for (int w = 0; w < 2; w++) begin
            mode    = 2'(m);
            stretch = 2'(s);
            runAccess(idx, w[0], 2'(r));
            idx++;
          end
        end
      end
    end

    // R11: with the request removed during the ready pulse, nothing restarts
    reqValid = 1'b0;
    stray = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (reqReady || intWrEn || dataOe || !rw || addrLo != 16'd0) stray++;
    end
    check(stray == 0, "R11", "bus idle after last request withdrawn", 32'(stray), 32'd0);

    summary();
    $finish;
  end

endmodule